// File: doc/BRIEF.md
# Stack Push Datapath

This block does the data and address work of a push in a small core. Each operation brings the current decode context (long mode or not, the default-size flag, an operand-size prefix and a wide-operand prefix), the kind of source, the width of the source and its raw value. The block settles the effective operand size and lowers the stack pointer by 2, 4 or 8 bytes. It then forms a 64-bit store word with per-byte lane enables and offers it to a memory port through a valid/ready handshake.

The stack pointer is an internal register that the block brings out. It takes the new value only in the cycle the memory port accepts the store. A store that stalls therefore leaves the architectural pointer where it was. Only one push is in flight at a time. While a store is pending, the block refuses new operations by holding `op_ready` low.

Top module: `push_dp`

## Requirements
- R1: Operand size: outside long mode (`mode_long`=0) the size is 32 bits when `def_wide` XOR `pfx_opsize` is 1, else 16 bits, and `pfx_wide` has no effect. In long mode the size is 64 bits when `pfx_wide`=1; otherwise it is 16 bits when `pfx_opsize`=1, and 64 bits when it is not.
- R2: An accepted push presents `wr_addr` = `sp` − 2, 4 or 8 for 16-, 32- and 64-bit operand sizes. `wr_valid` goes high in the cycle after the acceptance edge.
- R3: For a register source (`src_kind`=0) or a memory source (`src_kind`=1), the store word is the low operand-size bits of `src_value`, and all bits above them are zero.
- R4: For an immediate source (`src_kind`=2) with `src_width` 0/1/2/3 = 8/16/32/64 bits, the value is sign-extended from the source width to the operand size. When the source is at least as wide as the operand size, the value is truncated to the operand size.
- R5: A segment selector (`src_kind`=3) pushed at 64-bit size is the low 16 bits of `src_value`, zero-extended to 64 bits, with all 8 lanes enabled.
- R6: A segment selector pushed at 32-bit or 16-bit size enables only lanes 0 and 1 (`wr_be`=8'h03), so the upper bytes of the slot keep their old contents. The pointer still drops by the full operand size.
- R7: `wr_be` enables the low lanes, counted from the new pointer: 8'h03, 8'h0F or 8'hFF for 2-, 4- or 8-byte stores.
- R8: While `wr_valid`=1 and `wr_ready`=0, `wr_addr`, `wr_data`, `wr_be` and `sp` hold their values.
- R9: At the edge where `wr_valid` and `wr_ready` are both 1, `sp` takes the value of `wr_addr` and `wr_valid` falls.
- R10: After reset, `sp` equals parameter `SP_RESET`, `wr_valid`=0 and `op_ready`=1.
- R11: `op_valid` has no effect while `op_ready`=0. The pending store is unchanged, and the pointer moves by one push only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A push operation is offered |
| op_ready | output | 1 | The block can accept a push |
| mode_long | input | 1 | 64-bit mode context |
| def_wide | input | 1 | Default-size flag (32-bit default outside long mode) |
| pfx_opsize | input | 1 | Operand-size prefix present |
| pfx_wide | input | 1 | Wide-operand prefix present |
| src_kind | input | 2 | 0 register, 1 memory, 2 immediate, 3 segment selector |
| src_width | input | 2 | Source width: 0=8, 1=16, 2=32, 3=64 bits |
| src_value | input | 64 | Raw source value |
| wr_valid | output | 1 | Store request |
| wr_ready | input | 1 | Memory port accepts the store |
| wr_addr | output | AW | Store address (new top of stack) |
| wr_data | output | 64 | Store word, lane 0 at `wr_addr` |
| wr_be | output | 8 | Per-byte lane enables |
| sp | output | AW | Architectural stack pointer |

## Verification
The size logic is exercised with every prefix combination in both modes, each observed through the step in the address. This shows whether the mode, the default flag or each prefix actually reaches the decision. Immediates with the sign bit set and with it clear, at several source widths, separate sign extension from zero extension and from truncation. Register values with garbage above the operand size show that the value is masked. Segment selectors at 16, 32 and 64 bits contrast the two-lane store with the full-slot store at the same pointer step. A stalled store with a stray `op_valid` separates commit-on-acceptance from commit-on-issue, and shows that a busy block ignores new operations.

// File: rtl/push_pkg.sv
package push_pkg;

  localparam int PUSH_DW    = 64;
  localparam int PUSH_LANES = PUSH_DW / 8;

  typedef enum logic [1:0] {
    OS16 = 2'd0,
    OS32 = 2'd1,
    OS64 = 2'd2
  } opsize_e;

  typedef enum logic [1:0] {
    SRC_REG = 2'd0,
    SRC_MEM = 2'd1,
    SRC_IMM = 2'd2,
    SRC_SEG = 2'd3
  } src_kind_e;

  // Effective operand size from mode, default flag and prefixes.
  function automatic opsize_e pick_size(input logic long_m, input logic dflt,
                                        input logic p_os, input logic p_w);
    opsize_e s;
    if (long_m) begin
      if (p_w)       s = OS64;
      else if (p_os) s = OS16;
      else           s = OS64;
    end else begin
      s = (dflt ^ p_os) ? OS32 : OS16;
    end
    return s;
  endfunction

  // Bytes the pointer moves for a given size.
  function automatic logic [3:0] size_bytes(input opsize_e s);
    logic [3:0] n;
    case (s)
      OS16:    n = 4'd2;
      OS32:    n = 4'd4;
      default: n = 4'd8;
    endcase
    return n;
  endfunction

  // Bytes actually written: selectors below 64-bit size use a 2-byte store.
  function automatic logic [3:0] store_bytes(input src_kind_e k, input opsize_e s);
    logic [3:0] n;
    if (k == SRC_SEG && s != OS64) n = 4'd2;
    else                           n = size_bytes(s);
    return n;
  endfunction

  // Widen the raw source according to its kind and width.
  function automatic logic [PUSH_DW-1:0] widen(input src_kind_e k, input logic [1:0] w,
                                               input logic [PUSH_DW-1:0] v);
    logic [PUSH_DW-1:0] r;
    case (k)
      SRC_IMM: begin
        case (w)
          2'd0:    r = {{56{v[7]}},  v[7:0]};
          2'd1:    r = {{48{v[15]}}, v[15:0]};
          2'd2:    r = {{32{v[31]}}, v[31:0]};
          default: r = v;
        endcase
      end
      SRC_SEG: r = {48'd0, v[15:0]};
      default: r = v;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/push_size_sel.sv
module push_size_sel
  import push_pkg::*;
(
  input  logic    mode_long,
  input  logic    def_wide,
  input  logic    pfx_opsize,
  input  logic    pfx_wide,
  output opsize_e opsize,
  output logic [3:0] step_bytes
);

  assign opsize     = pick_size(mode_long, def_wide, pfx_opsize, pfx_wide);
  assign step_bytes = size_bytes(opsize);

  // R1: outside long mode the size never reaches 64 bits
  always_comb begin
    if (!mode_long) begin
      a_r1_no_wide_outside_long: assert (opsize != OS64);
    end
  end

endmodule

// File: rtl/push_value_fmt.sv
module push_value_fmt
  import push_pkg::*;
(
  input  src_kind_e               kind,
  input  logic [1:0]              src_width,
  input  logic [PUSH_DW-1:0]      src_value,
  input  opsize_e                 opsize,
  output logic [PUSH_DW-1:0]      data,
  output logic [PUSH_LANES-1:0]   be
);

  logic [3:0]          n_store;
  logic [PUSH_DW-1:0]  wide_val;

  assign n_store  = store_bytes(kind, opsize);
  assign wide_val = widen(kind, src_width, src_value);

  for (genvar g = 0; g < PUSH_LANES; g++) begin : g_lane
    assign be[g]           = (4'(g) < n_store);
    assign data[8*g +: 8]  = be[g] ? wide_val[8*g +: 8] : 8'h00;
  end

  // R6: a selector below 64-bit size writes exactly two lanes
  always_comb begin
    if (kind == SRC_SEG && opsize != OS64) begin
      a_r6_seg_two_lanes: assert (be == 8'h03);
    end
  end

endmodule

// File: rtl/push_wr_ctrl.sv
module push_wr_ctrl
  import push_pkg::*;
#(
  parameter int              AW       = 32,
  parameter logic [AW-1:0]   SP_RESET = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  accept,
  input  logic [3:0]            step_bytes,
  input  logic [PUSH_DW-1:0]    data_in,
  input  logic [PUSH_LANES-1:0] be_in,
  input  logic                  wr_ready,
  output logic                  wr_valid,
  output logic [AW-1:0]         wr_addr,
  output logic [PUSH_DW-1:0]    wr_data,
  output logic [PUSH_LANES-1:0] wr_be,
  output logic [AW-1:0]         sp
);

  logic [AW-1:0] sp_q;
  logic [AW-1:0] next_top;
  logic          wr_fire;
  logic [AW-1:0] pend_step;

  assign next_top  = sp_q - {{(AW-4){1'b0}}, step_bytes};
  assign wr_fire   = wr_valid & wr_ready;
  assign pend_step = sp_q - wr_addr;
  assign sp        = sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q     <= SP_RESET;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      wr_be    <= '0;
    end else begin
      if (accept) begin
        wr_valid <= 1'b1;
        wr_addr  <= next_top;
        wr_data  <= data_in;
        wr_be    <= be_in;
      end else if (wr_fire) begin
        wr_valid <= 1'b0;
        sp_q     <= wr_addr;
      end
    end
  end

  a_r2_step_size: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (pend_step == AW'(2) || pend_step == AW'(4) || pend_step == AW'(8)));

  a_r7_low_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_be == 8'h03 || wr_be == 8'h0F || wr_be == 8'hFF));

  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)
                                 && $stable(wr_be) && $stable(sp_q)));

  a_r9_commit_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (!wr_valid && sp_q == $past(wr_addr)));

  a_r11_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !accept);

  a_r9_sp_only_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(sp_q));

endmodule

// File: rtl/push_dp.sv
module push_dp
  import push_pkg::*;
#(
  parameter int            AW       = 32,
  parameter logic [AW-1:0] SP_RESET = AW'(32'h0000_8000)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_valid,
  output logic                  op_ready,
  input  logic                  mode_long,
  input  logic                  def_wide,
  input  logic                  pfx_opsize,
  input  logic                  pfx_wide,
  input  logic [1:0]            src_kind,
  input  logic [1:0]            src_width,
  input  logic [63:0]           src_value,
  output logic                  wr_valid,
  input  logic                  wr_ready,
  output logic [AW-1:0]         wr_addr,
  output logic [63:0]           wr_data,
  output logic [7:0]            wr_be,
  output logic [AW-1:0]         sp
);

  opsize_e                opsize;
  logic [3:0]             step_bytes;
  logic [PUSH_DW-1:0]     fmt_data;
  logic [PUSH_LANES-1:0]  fmt_be;
  logic                   accept;

  assign op_ready = ~wr_valid;
  assign accept   = op_valid & op_ready;

  push_size_sel u_size (
    .mode_long  (mode_long),
    .def_wide   (def_wide),
    .pfx_opsize (pfx_opsize),
    .pfx_wide   (pfx_wide),
    .opsize     (opsize),
    .step_bytes (step_bytes)
  );

  push_value_fmt u_fmt (
    .kind      (src_kind_e'(src_kind)),
    .src_width (src_width),
    .src_value (src_value),
    .opsize    (opsize),
    .data      (fmt_data),
    .be        (fmt_be)
  );

  push_wr_ctrl #(.AW(AW), .SP_RESET(SP_RESET)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .step_bytes (step_bytes),
    .data_in    (fmt_data),
    .be_in      (fmt_be),
    .wr_ready   (wr_ready),
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .wr_be      (wr_be),
    .sp         (sp)
  );

endmodule

// File: tb/push_dp_bench.sv
module push_dp_bench;

  localparam int          AW       = 32;
  localparam logic [31:0] SP_RESET = 32'h0000_8000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic        mode_long = 1'b0, def_wide = 1'b0, pfx_opsize = 1'b0, pfx_wide = 1'b0;
  logic [1:0]  src_kind = 2'd0, src_width = 2'd0;
  logic [63:0] src_value = 64'd0;
  logic        wr_valid;
  logic        wr_ready = 1'b0;
  logic [31:0] wr_addr;
  logic [63:0] wr_data;
  logic [7:0]  wr_be;
  logic [31:0] sp;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] exp_sp;

  always #5 clk = ~clk;

  push_dp #(.AW(AW), .SP_RESET(SP_RESET)) u_push_dp (
    .clk, .rst_n, .op_valid, .op_ready, .mode_long, .def_wide, .pfx_opsize,
    .pfx_wide, .src_kind, .src_width, .src_value, .wr_valid, .wr_ready,
    .wr_addr, .wr_data, .wr_be, .sp
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_data(input int kind, input int wbits,
                                           input logic [63:0] v, input int nbytes);
    logic [63:0] x;
    if (kind == 2)      x = 64'($signed(v << (64 - wbits)) >>> (64 - wbits));
    else if (kind == 3) x = {48'h0, v[15:0]};
    else                x = v;
    if (nbytes < 8) x = x & ((64'h1 << (8 * nbytes)) - 64'h1);
    return x;
  endfunction

  // Offer one push; returns with the request visible.
  task automatic issue(input logic ml, input logic dw, input logic po, input logic pw,
                       input int kind, input int swc, input logic [63:0] val);
    @(negedge clk);
    mode_long = ml; def_wide = dw; pfx_opsize = po; pfx_wide = pw;
    src_kind = 2'(kind); src_width = 2'(swc); src_value = val;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic complete(input string req);
    wr_ready = 1'b1;
    @(negedge clk);
    wr_ready = 1'b0;
    chk(req, {32'h0, sp}, {32'h0, exp_sp});
    chk(req, {63'h0, wr_valid}, 64'h0);
  endtask

  task automatic push_check(input string req, input logic ml, input logic dw,
                            input logic po, input logic pw, input int kind,
                            input int swc, input logic [63:0] val,
                            input int step, input int nstore);
    logic [31:0] top;
    issue(ml, dw, po, pw, kind, swc, val);
    top = exp_sp - 32'(step);
    chk(req, {63'h0, wr_valid}, 64'h1);
    chk(req, {32'h0, wr_addr}, {32'h0, top});
    chk({req, " R7"}, {56'h0, wr_be}, {56'h0, 8'((16'h1 << nstore) - 16'h1)});
    chk(req, wr_data, ref_data(kind, 8 << swc, val, nstore));
    exp_sp = top;
    complete({req, " R9"});
  endtask

  task automatic t_reset;
    chk("R10 sp", {32'h0, sp}, {32'h0, SP_RESET});
    chk("R10 wr_valid", {63'h0, wr_valid}, 64'h0);
    chk("R10 op_ready", {63'h0, op_ready}, 64'h1);
  endtask

  task automatic t_sizes;
    push_check("R1 legacy d0",      0, 0, 0, 0, 0, 3, 64'h1111_2222_3333_4444, 2, 2);
    push_check("R1 legacy d1",      0, 1, 0, 0, 0, 3, 64'h1111_2222_3333_4444, 4, 4);
    push_check("R1 legacy d0 pfx",  0, 0, 1, 0, 0, 3, 64'h1111_2222_3333_4444, 4, 4);
    push_check("R1 legacy d1 pfx",  0, 1, 1, 0, 0, 3, 64'h1111_2222_3333_4444, 2, 2);
    push_check("R1 legacy wide ign",0, 1, 0, 1, 0, 3, 64'h1111_2222_3333_4444, 4, 4);
    push_check("R1 long default",   1, 0, 0, 0, 0, 3, 64'h1111_2222_3333_4444, 8, 8);
    push_check("R1 long pfx16",     1, 1, 1, 0, 0, 3, 64'h1111_2222_3333_4444, 2, 2);
    push_check("R1 long wide wins", 1, 0, 1, 1, 0, 3, 64'h1111_2222_3333_4444, 8, 8);
  endtask

  task automatic t_reg_mem;
    push_check("R3 reg16 masked",  0, 0, 0, 0, 0, 3, 64'hDEAD_BEEF_CAFE_F00D, 2, 2);
    push_check("R3 mem32 masked",  0, 1, 0, 0, 1, 3, 64'hDEAD_BEEF_8765_4321, 4, 4);
    push_check("R2 R3 reg64",      1, 0, 0, 0, 0, 3, 64'h8000_0000_0000_0001, 8, 8);
  endtask

  task automatic t_imm;
    push_check("R4 imm8 neg to 64",  1, 0, 0, 0, 2, 0, 64'h0000_0000_0000_0080, 8, 8);
    push_check("R4 imm8 pos to 32",  0, 1, 0, 0, 2, 0, 64'hFFFF_FFFF_FFFF_FF7F, 4, 4);
    push_check("R4 imm16 neg to 32", 0, 1, 0, 0, 2, 1, 64'h0000_0000_0000_8001, 4, 4);
    push_check("R4 imm32 neg to 64", 1, 0, 0, 0, 2, 2, 64'h0000_0000_F000_0002, 8, 8);
    push_check("R4 imm32 trunc 16",  0, 0, 0, 0, 2, 2, 64'h0000_0000_1234_F678, 2, 2);
  endtask

  task automatic t_seg;
    push_check("R5 seg64 zero ext",  1, 0, 0, 0, 3, 1, 64'hFFFF_FFFF_FFFF_ABCD, 8, 8);
    push_check("R6 seg32 two lanes", 0, 1, 0, 0, 3, 1, 64'hFFFF_FFFF_FFFF_9ABC, 4, 2);
    push_check("R6 seg16",           0, 0, 0, 0, 3, 1, 64'h0000_0000_5555_0123, 2, 2);
  endtask

  task automatic t_stall_busy;
    logic [31:0] top;
    issue(0, 1, 0, 0, 0, 3, 64'h0000_0000_CAFE_0001);
    top = exp_sp - 32'd4;
    repeat (3) @(negedge clk);
    chk("R8 addr held", {32'h0, wr_addr}, {32'h0, top});
    chk("R8 data held", wr_data, 64'h0000_0000_CAFE_0001);
    chk("R8 sp held",   {32'h0, sp}, {32'h0, exp_sp});
    chk("R8 valid held", {63'h0, wr_valid}, 64'h1);
    chk("R11 busy", {63'h0, op_ready}, 64'h0);
    // stray offer while busy
    src_kind = 2'd3; src_value = 64'h0000_0000_0000_7777;
    mode_long = 1'b1; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R11 addr unchanged", {32'h0, wr_addr}, {32'h0, top});
    chk("R11 data unchanged", wr_data, 64'h0000_0000_CAFE_0001);
    chk("R11 be unchanged",   {56'h0, wr_be}, 64'h0F);
    exp_sp = top;
    complete("R9 R11 single step");
    @(negedge clk);
    chk("R11 no late request", {63'h0, wr_valid}, 64'h0);
    chk("R11 sp once", {32'h0, sp}, {32'h0, exp_sp});
  endtask

  initial begin
    exp_sp = SP_RESET;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sizes();
    t_reg_mem();
    t_imm();
    t_seg();
    t_stall_busy();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule